// File: doc/BRIEF.md
# Read-Modify-Write Bus Sequencer

This block drives the data-memory side of an 8-bit processor's read-modify-write instructions: shift left, shift right, rotate left, rotate right, increment and decrement applied to a byte in memory. The surrounding core has already decoded the instruction and computed the effective address. It hands over an operation code, that address and the current carry flag with a one-clock start strobe. The sequencer then makes three bus accesses to the same address. First it reads the operand. Next it writes the unmodified byte back. Last it writes the modified byte.

The write of the unchanged value is kept on purpose and costs one bus access. Peripheral registers that clear their pending bits when a one is written to them rely on it. An interrupt acknowledge such as "increment the status register" then clears every pending source that was read, whatever the arithmetic result is. Every access is held until the memory side lowers its wait input. When the final write is accepted, the negative, zero and carry results are published and a one-clock done pulse is raised.

Top module: `rmw_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, the read and write strobes, the done pulse and all three flag outputs are 0.
- R2: A start pulse seen while idle launches a read of `addr_i` in the next cycle. A start pulse seen while a sequence is running is ignored, and no access is made to its address.
- R3: While `mem_wait_i` is high during an access, the address, strobes and write data stay unchanged. An access completes on a rising clock edge where its strobe is high and `mem_wait_i` is low.
- R4: The accesses come in a fixed order at the one address: a read, then a write of the exact byte read, then a write of the modified byte.
- R5: Op code 0 shifts left and op code 1 shifts right. Each fills the vacated bit with 0 and sets the carry result to the bit shifted out.
- R6: Op code 2 rotates left through carry and op code 3 rotates right through carry. The `carry_i` value sampled at start enters the vacated bit, and the bit shifted out becomes the carry result.
- R7: Op code 4 adds one and op code 5 subtracts one, both modulo 256. For these the carry result equals the `carry_i` value sampled at start.
- R8: The negative result is bit 7 of the modified byte. The zero result is 1 exactly when the modified byte is 0.
- R9: `done_o` is high for exactly one clock, in the cycle after the final write completes. The flag outputs change only in that cycle.
- R10: From the clock edge that samples start to the edge after which `done_o` is high, the sequence takes 4 clocks plus one clock for each wait cycle. One wait state per access gives 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, one clock |
| op_i | input | 3 | Operation: 0 shl, 1 shr, 2 rotl, 3 rotr, 4 inc, 5 dec |
| addr_i | input | 16 | Effective address of the operand |
| carry_i | input | 1 | Carry flag value at start |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid on the completing edge |
| mem_wait_i | input | 1 | High stretches the current access |
| flag_n_o | output | 1 | Negative result |
| flag_z_o | output | 1 | Zero result |
| flag_c_o | output | 1 | Carry result |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The assertions assume that the memory side presents valid read data on the edge where it lowers `mem_wait_i`. They also assume that `mem_wait_i` changes only between clock edges and that `op_i` is one of the six defined codes when start is pulsed. The bench models memory that meets these rules. It draws each access's wait count from a bounded range, or holds the count at a fixed value for the latency cases. It drives wait and start on the falling edge and issues only codes 0 to 5. One directed case pulses start in the middle of a sequence, pointing at a second address, to show that the pulse is dropped.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    localparam logic [2:0] OP_SHL  = 3'd0;
    localparam logic [2:0] OP_SHR  = 3'd1;
    localparam logic [2:0] OP_ROTL = 3'd2;
    localparam logic [2:0] OP_ROTR = 3'd3;
    localparam logic [2:0] OP_INC  = 3'd4;
    localparam logic [2:0] OP_DEC  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ    = 2'd1,
        ST_WR_ORIG = 2'd2,
        ST_WR_MOD  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/rmw_alu.sv
module rmw_alu #(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] result_o,
    output logic              cout_o
);
    import rmw_pkg::*;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        result_o = operand_i;
        cout_o   = cin_i;
        case (op_i)
            OP_SHL:  {cout_o, result_o} = {operand_i, 1'b0};
            OP_SHR:  {result_o, cout_o} = {1'b0, operand_i};
            OP_ROTL: {cout_o, result_o} = {operand_i, cin_i};
            OP_ROTR: {result_o, cout_o} = {cin_i, operand_i};
            OP_INC:  result_o = operand_i + ONE;
            OP_DEC:  result_o = operand_i - ONE;
            default: result_o = operand_i;
        endcase
    end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              carry_i,
    input  logic              mem_wait_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic [DATA_W-1:0] alu_res_i,
    input  logic              alu_cout_i,
    output logic [2:0]        alu_op_o,
    output logic [DATA_W-1:0] alu_opnd_o,
    output logic              alu_cin_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_c_o,
    output logic              done_o
);
    import rmw_pkg::*;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        op;
        logic              cin;
        logic [DATA_W-1:0] opnd;
        logic              n;
        logic              z;
        logic              c;
        logic              done;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st   = ST_READ;
                    seq_d.addr = addr_i;
                    seq_d.op   = op_i;
                    seq_d.cin  = carry_i;
                end
            end
            ST_READ: begin
                if (!mem_wait_i) begin
                    seq_d.opnd = mem_rdata_i;
                    seq_d.st   = ST_WR_ORIG;
                end
            end
            ST_WR_ORIG: begin
                if (!mem_wait_i) seq_d.st = ST_WR_MOD;
            end
            ST_WR_MOD: begin
                if (!mem_wait_i) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                    seq_d.n    = alu_res_i[DATA_W-1];
                    seq_d.z    = (alu_res_i == '0);
                    seq_d.c    = alu_cout_i;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign alu_op_o    = seq_q.op;
    assign alu_opnd_o  = seq_q.opnd;
    assign alu_cin_o   = seq_q.cin;
    assign mem_addr_o  = seq_q.addr;
    assign mem_rd_o    = (seq_q.st == ST_READ);
    assign mem_wr_o    = (seq_q.st == ST_WR_ORIG) || (seq_q.st == ST_WR_MOD);
    assign mem_wdata_o = (seq_q.st == ST_WR_MOD) ? alu_res_i : seq_q.opnd;
    assign flag_n_o    = seq_q.n;
    assign flag_z_o    = seq_q.z;
    assign flag_c_o    = seq_q.c;
    assign done_o      = seq_q.done;

    // Access held while memory stalls
    assert_hold_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd_o || mem_wr_o) && mem_wait_i) |=>
            ($stable(mem_addr_o) && $stable(mem_rd_o) && $stable(mem_wr_o)
             && $stable(mem_wdata_o)));

    // A completed read is followed by writing back the byte read, same address
    assert_orig_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_wait_i) |=>
            (mem_wr_o && mem_wdata_o == $past(mem_rdata_i)
             && mem_addr_o == $past(mem_addr_o)));

    // The strobes are never raised together
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o}));

    // Final write acceptance leads to done with the bus idle
    assert_done_after_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WR_MOD && !mem_wait_i) |=> (done_o && !mem_rd_o && !mem_wr_o));

    // done lasts a single clock
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Flags move only with done
    assert_flags_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({flag_n_o, flag_z_o, flag_c_o}));

    // N and Z describe the byte of the last write
    assert_nz_from_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flag_z_o == ($past(mem_wdata_o) == '0)
                    && flag_n_o == $past(mem_wdata_o[DATA_W-1])));
endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              carry_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_wait_i,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_c_o,
    output logic              done_o
);
    logic [2:0]        alu_op;
    logic [DATA_W-1:0] alu_opnd;
    logic              alu_cin;
    logic [DATA_W-1:0] alu_res;
    logic              alu_cout;

    rmw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .op_i        (op_i),
        .addr_i      (addr_i),
        .carry_i     (carry_i),
        .mem_wait_i  (mem_wait_i),
        .mem_rdata_i (mem_rdata_i),
        .alu_res_i   (alu_res),
        .alu_cout_i  (alu_cout),
        .alu_op_o    (alu_op),
        .alu_opnd_o  (alu_opnd),
        .alu_cin_o   (alu_cin),
        .mem_addr_o  (mem_addr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .mem_wdata_o (mem_wdata_o),
        .flag_n_o    (flag_n_o),
        .flag_z_o    (flag_z_o),
        .flag_c_o    (flag_c_o),
        .done_o      (done_o)
    );

    rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i      (alu_op),
        .operand_i (alu_opnd),
        .cin_i     (alu_cin),
        .result_o  (alu_res),
        .cout_o    (alu_cout)
    );
endmodule

// File: tb/rmw_sequencer_test.sv
module rmw_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [15:0] addr_i = '0;
    logic        carry_i = 1'b0;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o, mem_wr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i;
    logic        mem_wait_i = 1'b0;
    logic        flag_n_o, flag_z_o, flag_c_o, done_o;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] mem [256];
    assign mem_rdata_i = mem[mem_addr_o[7:0]];

    // access log: kind 0 read, 1 write
    logic        log_kind [8];
    logic [15:0] log_addr [8];
    logic [7:0]  log_data [8];
    int log_n = 0;
    int in_acc = 0;
    int wleft = 0;
    int waits = 0;
    int wait_max = 0;
    int wait_fix = -1;

    always #4 clk = ~clk;

    rmw_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .addr_i(addr_i), .carry_i(carry_i), .mem_addr_o(mem_addr_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_wait_i(mem_wait_i),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
        .done_o(done_o)
    );

    always @(negedge clk) begin
        if (rst_n && (mem_rd_o || mem_wr_o)) begin
            if (in_acc == 0) begin
                in_acc = 1;
                wleft = (wait_fix >= 0) ? wait_fix : int'($urandom_range(0, wait_max));
            end
            if (wleft > 0) begin
                mem_wait_i = 1'b1;
                wleft = wleft - 1;
                waits = waits + 1;
            end else begin
                mem_wait_i = 1'b0;
            end
        end else begin
            mem_wait_i = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst_n && (mem_rd_o || mem_wr_o) && !mem_wait_i) begin
            if (log_n < 8) begin
                log_kind[log_n] = mem_wr_o;
                log_addr[log_n] = mem_addr_o;
                log_data[log_n] = mem_wr_o ? mem_wdata_o : mem_rdata_i;
            end
            log_n = log_n + 1;
            if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
            in_acc = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] model(input logic [2:0] op, input logic [7:0] v, input logic c);
        case (op)
            3'd0: return {v[7], v[6:0], 1'b0};
            3'd1: return {v[0], 1'b0, v[7:1]};
            3'd2: return {v[7], v[6:0], c};
            3'd3: return {v[0], c, v[7:1]};
            3'd4: return {c, v + 8'd1};
            default: return {c, v - 8'd1};
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [15:0] a, input logic c,
                          input logic [7:0] init, input bit poke_busy, input int exp_lat);
        logic [8:0] e;
        logic [15:0] other;
        int cnt;
        string rq;
        e = model(op, init, c);
        other = a + 16'd1;
        mem[a[7:0]] = init;
        mem[other[7:0]] = 8'h5a;
        log_n = 0;
        waits = 0;
        @(negedge clk);
        start_i = 1'b1; op_i = op; addr_i = a; carry_i = c;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 1;
        while (!done_o && cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (poke_busy && cnt == 2) begin
                start_i = 1'b1; addr_i = other; op_i = 3'd4;
            end else begin
                start_i = 1'b0;
            end
        end
        rq = (op < 2) ? "R5" : (op < 4) ? "R6" : "R7";
        chk(log_n == 3, "R4 access count", log_n, 3);
        chk(log_kind[0] == 1'b0 && log_addr[0] == a && log_data[0] == init,
            "R2 R4 read", log_data[0], init);
        chk(log_kind[1] == 1'b1 && log_addr[1] == a && log_data[1] == init,
            "R4 write original", log_data[1], init);
        chk(log_kind[2] == 1'b1 && log_addr[2] == a && log_data[2] == e[7:0],
            {rq, " modified write"}, log_data[2], e[7:0]);
        chk(flag_c_o == e[8], {rq, " carry"}, flag_c_o, e[8]);
        chk(flag_n_o == e[7], "R8 negative", flag_n_o, e[7]);
        chk(flag_z_o == (e[7:0] == 8'd0), "R8 zero", flag_z_o, e[7:0] == 8'd0);
        chk(cnt == 4 + waits, "R10 latency", cnt, 4 + waits);
        if (exp_lat > 0) chk(cnt == exp_lat, "R10 one wait per access", cnt, exp_lat);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done width", done_o, 0);
        chk({flag_n_o, flag_z_o, flag_c_o} == {e[7], e[7:0] == 8'd0, e[8]},
            "R9 flags held", {flag_n_o, flag_z_o, flag_c_o}, {e[7], e[7:0] == 8'd0, e[8]});
        if (poke_busy) begin
            repeat (2) @(negedge clk);
            chk(!mem_rd_o && !mem_wr_o && log_n == 3, "R2 busy start ignored", log_n, 3);
            chk(mem[other[7:0]] == 8'h5a, "R2 other address untouched", mem[other[7:0]], 8'h5a);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!mem_rd_o && !mem_wr_o && !done_o && !flag_n_o && !flag_z_o && !flag_c_o,
            "R1 reset state", {mem_rd_o, mem_wr_o, done_o, flag_n_o, flag_z_o, flag_c_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_rd_o && !mem_wr_o && !done_o && !flag_c_o, "R1 after reset",
            {mem_rd_o, mem_wr_o, done_o, flag_c_o}, 0);

        // directed corner cases, no waits
        wait_fix = 0;
        run_op(3'd0, 16'h1080, 1'b0, 8'h80, 1'b0, 4);   // R5 shl to zero, carry out
        run_op(3'd1, 16'h2001, 1'b1, 8'h01, 1'b0, 4);   // R5 shr ignores carry in
        run_op(3'd2, 16'h3002, 1'b1, 8'h7f, 1'b0, 4);   // R6 rotl carry in
        run_op(3'd3, 16'h4003, 1'b1, 8'h00, 1'b0, 4);   // R6 rotr to 0x80
        run_op(3'd4, 16'h5004, 1'b1, 8'hff, 1'b0, 4);   // R7 inc wrap, carry kept
        run_op(3'd5, 16'h6005, 1'b0, 8'h00, 1'b0, 4);   // R7 dec wrap
        run_op(3'd4, 16'h7010, 1'b0, 8'h7f, 1'b1, 4);   // R2 start while busy
        // one wait state per access
        wait_fix = 1;
        run_op(3'd5, 16'h8020, 1'b1, 8'h01, 1'b0, 7);   // R10 R8 dec to zero
        run_op(3'd0, 16'h8021, 1'b0, 8'h55, 1'b1, 7);
        // random mix with random stalls (R3)
        wait_fix = -1;
        wait_max = 3;
        for (int k = 0; k < 60; k++) begin
            run_op(3'($urandom_range(0, 5)), 16'($urandom), 1'($urandom),
                   8'($urandom), 1'(k % 7 == 0), 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule